// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the processor's entry into an accepted hardware interrupt. When the interrupt controller hands over an accepted request, the sequencer takes a snapshot of the processor context, the system stack bank and pointer, the request number, its level and the source's service-type bit. If that bit selects an ordinary interrupt, the sequencer pushes the context onto the stack one byte at a time. It then fetches a three-byte vector and presents the new program counter, the new bank and the updated status word.

Memory is reached through a byte-wide request/acknowledge port, and the memory may stretch any access with wait cycles. The register file stays outside the block: its current values arrive on input ports, and the values to load come back on output ports, valid in the cycle `branch` is high. If the service-type bit selects some other kind of service, the block only raises `svc_req` for one cycle and leaves the stack alone.

Top module: `irq_entry_seq`

## Requirements
- R1: After synchronous reset, `busy`, `mem_req`, `branch` and `svc_req` are all 0.
- R2: When `irq_mode` is 1 at `start`, `svc_req` is high for exactly one cycle, no memory access is made, `branch` stays low and the block returns to idle.
- R3: With `irq_mode` 0, exactly 12 bytes are written, at `{ssb, ssp-1}`, `{ssb, ssp-2}` … `{ssb, ssp-12}` (16-bit pointer arithmetic that wraps, bank unchanged). The bytes are, in that order: status high, status low, PC high, PC low, PCB, DTB, ADB, DPR, then A from bits 31:24 down to bits 7:0.
- R4: After the writes, three reads are made at `VEC_BASE - 4*irq_num`, `+1` and `+2`.
- R5: At `branch`, `pc_out` is {second read byte, first read byte} and `pcb_out` is the third read byte.
- R6: At `branch`, `ps_out` equals the saved status word with bits 15:13 replaced by `irq_level` and bit 5 (stack select) set; all other bits are unchanged.
- R7: At `branch`, `ssp_out` equals the sampled stack pointer minus 12, modulo 2^16.
- R8: A request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until `mem_ack`, so any number of wait cycles is tolerated.
- R9: `branch` is a single-cycle pulse one cycle after the acknowledge of the third vector read; `busy` is 0 in the following cycle.
- R10: `start` and all context inputs are ignored while `busy` is 1. Results depend only on the values sampled when the sequence was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accepted interrupt; samples all context inputs when idle |
| irq_num | input | NUM_W | Interrupt number |
| irq_level | input | 3 | Level of the accepted request |
| irq_mode | input | 1 | Service-type bit of the source (0 = ordinary interrupt) |
| ps_in | input | 16 | Current status word |
| pc_in | input | 16 | Current program counter |
| pcb_in | input | 8 | Current program bank |
| dtb_in | input | 8 | Data bank |
| adb_in | input | 8 | Additional bank |
| dpr_in | input | 8 | Direct page register |
| acc_in | input | 32 | Accumulator |
| ssb_in | input | 8 | System stack bank |
| ssp_in | input | 16 | System stack pointer |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address {bank, offset} |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Completes the current access |
| busy | output | 1 | Sequence in progress |
| branch | output | 1 | One-cycle pulse: the outputs below are valid, jump now |
| svc_req | output | 1 | One-cycle pulse: other service type requested |
| pc_out | output | 16 | New program counter |
| pcb_out | output | 8 | New program bank |
| ps_out | output | 16 | New status word |
| ssp_out | output | 16 | Decremented stack pointer |

## Verification
A fixed context with distinct bytes shows whether the push order is right and whether each byte is placed correctly. Random contexts, levels and interrupt numbers 0 and 255 exercise the vector address and the status merge. A stack pointer of 5 makes the pointer wrap within the bank, which separates 16-bit arithmetic from 24-bit arithmetic. Random wait states on the responder test the handshake, a case with the service-type bit set must produce no writes, and a second `start` with new context during a sequence must leave the results unchanged.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int CTX_BYTES = 12;
    localparam int VEC_BYTES = 3;
    localparam int CNT_W     = $clog2(CTX_BYTES + 1);
    localparam int ILM_W     = 3;
    localparam int ILM_LSB   = 13;
    localparam int S_BIT     = 5;
    localparam int BANK_W    = 8;
    localparam int PTR_W     = 16;
    localparam int ADDR_W    = BANK_W + PTR_W;

    // Field order equals push order, most significant byte first.
    typedef struct packed {
        logic [15:0] ps;
        logic [15:0] pc;
        logic [7:0]  pcb;
        logic [7:0]  dtb;
        logic [7:0]  adb;
        logic [7:0]  dpr;
        logic [31:0] acc;
    } ctx_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PUSH,
        ST_VEC,
        ST_DONE,
        ST_SVC
    } seq_state_t;

    function automatic logic [7:0] ctx_byte(input ctx_t c, input int unsigned k);
        logic [8*CTX_BYTES-1:0] flat;
        flat = c;
        return flat[8*(CTX_BYTES-1-k) +: 8];
    endfunction

    function automatic logic [15:0] enter_ps(input logic [15:0] ps,
                                             input logic [ILM_W-1:0] lvl);
        logic [15:0] r;
        r = ps;
        r[ILM_LSB +: ILM_W] = lvl;
        r[S_BIT] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/irq_push_mux.sv
module irq_push_mux
    import irq_entry_pkg::*;
(
    input  ctx_t             ctx,
    input  logic [CNT_W-1:0] idx,
    output logic [7:0]       byte_out
);
    logic [7:0] lane [CTX_BYTES];

    for (genvar g = 0; g < CTX_BYTES; g++) begin : g_lane
        assign lane[g] = ctx_byte(ctx, g);
    end

    always_comb begin
        byte_out = 8'h00;
        for (int k = 0; k < CTX_BYTES; k++) begin
            if (idx == CNT_W'(k)) byte_out = lane[k];
        end
    end
endmodule

// File: rtl/irq_vec_collect.sv
module irq_vec_collect
    import irq_entry_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cap,
    input  logic [1:0]  sel,
    input  logic [7:0]  rdata,
    output logic [15:0] pc_vec,
    output logic [7:0]  pcb_vec
);
    logic [7:0] slot [VEC_BYTES];

    for (genvar g = 0; g < VEC_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                          slot[g] <= 8'h00;
            else if (cap && sel == 2'(g))     slot[g] <= rdata;
        end
    end

    assign pc_vec  = {slot[1], slot[0]};
    assign pcb_vec = slot[2];
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mode_q,
    input  logic             mem_ack,
    output logic             accept,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [CNT_W-1:0] cnt_o,
    output logic             vec_cap,
    output logic             branch,
    output logic             svc_req
);
    localparam logic [CNT_W-1:0] LAST_PUSH = CNT_W'(CTX_BYTES - 1);
    localparam logic [CNT_W-1:0] LAST_VEC  = CNT_W'(VEC_BYTES - 1);

    seq_state_t       st;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st  <= ST_CHECK;
                    cnt <= '0;
                end
                ST_CHECK: st <= mode_q ? ST_SVC : ST_PUSH;
                ST_PUSH: if (mem_ack) begin
                    if (cnt == LAST_PUSH) begin
                        st  <= ST_VEC;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_VEC: if (mem_ack) begin
                    if (cnt == LAST_VEC) st <= ST_DONE;
                    else                 cnt <= cnt + CNT_W'(1);
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign accept  = (st == ST_IDLE) && start;
    assign busy    = (st != ST_IDLE);
    assign mem_req = (st == ST_PUSH) || (st == ST_VEC);
    assign mem_we  = (st == ST_PUSH);
    assign cnt_o   = cnt;
    assign vec_cap = (st == ST_VEC) && mem_ack;
    assign branch  = (st == ST_DONE);
    assign svc_req = (st == ST_SVC);

    // Independent count of completed writes, used only by the checks below.
    logic [CNT_W-1:0] wr_seen;
    always_ff @(posedge clk) begin
        if (rst || accept)                   wr_seen <= '0;
        else if (mem_req && mem_we && mem_ack) wr_seen <= wr_seen + CNT_W'(1);
    end

    assert_svc_nomem_R2: assert property (@(posedge clk) disable iff (rst)
        svc_req |-> (!$past(mem_req) && !mem_req && wr_seen == '0));

    assert_push_count_R3: assert property (@(posedge clk) disable iff (rst)
        branch |-> (wr_seen == CNT_W'(CTX_BYTES)));

    assert_vec_after_push_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (wr_seen == CNT_W'(CTX_BYTES)));

    assert_branch_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        branch |=> (!branch && !busy));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int                NUM_W    = 8,
    parameter logic [ADDR_W-1:0] VEC_BASE = 24'hFFFFFC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [NUM_W-1:0]  irq_num,
    input  logic [ILM_W-1:0]  irq_level,
    input  logic              irq_mode,
    input  logic [15:0]       ps_in,
    input  logic [15:0]       pc_in,
    input  logic [7:0]        pcb_in,
    input  logic [7:0]        dtb_in,
    input  logic [7:0]        adb_in,
    input  logic [7:0]        dpr_in,
    input  logic [31:0]       acc_in,
    input  logic [BANK_W-1:0] ssb_in,
    input  logic [PTR_W-1:0]  ssp_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              branch,
    output logic              svc_req,
    output logic [15:0]       pc_out,
    output logic [7:0]        pcb_out,
    output logic [15:0]       ps_out,
    output logic [PTR_W-1:0]  ssp_out
);
    ctx_t              ctx_q;
    logic [BANK_W-1:0] ssb_q;
    logic [PTR_W-1:0]  ssp_q;
    logic [ILM_W-1:0]  lvl_q;
    logic              mode_q;
    logic [ADDR_W-1:0] vec_addr_q;

    logic              accept;
    logic [CNT_W-1:0]  cnt;
    logic              vec_cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q      <= '0;
            ssb_q      <= '0;
            ssp_q      <= '0;
            lvl_q      <= '0;
            mode_q     <= 1'b0;
            vec_addr_q <= '0;
        end else if (accept) begin
            ctx_q      <= '{ps: ps_in, pc: pc_in, pcb: pcb_in, dtb: dtb_in,
                            adb: adb_in, dpr: dpr_in, acc: acc_in};
            ssb_q      <= ssb_in;
            ssp_q      <= ssp_in;
            lvl_q      <= irq_level;
            mode_q     <= irq_mode;
            vec_addr_q <= VEC_BASE - (ADDR_W'(irq_num) << 2);
        end
    end

    irq_entry_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mode_q  (mode_q),
        .mem_ack (mem_ack),
        .accept  (accept),
        .busy    (busy),
        .mem_req (mem_req),
        .mem_we  (mem_we),
        .cnt_o   (cnt),
        .vec_cap (vec_cap),
        .branch  (branch),
        .svc_req (svc_req)
    );

    irq_push_mux u_push (
        .ctx      (ctx_q),
        .idx      (cnt),
        .byte_out (mem_wdata)
    );

    irq_vec_collect u_vec (
        .clk     (clk),
        .rst     (rst),
        .cap     (vec_cap),
        .sel     (cnt[1:0]),
        .rdata   (mem_rdata),
        .pc_vec  (pc_out),
        .pcb_vec (pcb_out)
    );

    always_comb begin
        if (mem_we) mem_addr = {ssb_q, ssp_q - PTR_W'(cnt) - PTR_W'(1)};
        else        mem_addr = vec_addr_q + ADDR_W'(cnt[1:0]);
    end

    assign ps_out  = enter_ps(ctx_q.ps, lvl_q);
    assign ssp_out = ssp_q - PTR_W'(CTX_BYTES);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));
endmodule

// File: tb/test_irq_entry_seq.sv
`timescale 1ns/1ps
module test_irq_entry_seq;
    localparam logic [23:0] VB = 24'hFFFFFC;

    typedef struct packed {
        bit          svc;
        logic [15:0] pc;
        logic [7:0]  pcb;
        logic [15:0] ps;
        logic [15:0] ssp;
        logic [7:0]  ssb;
        logic [15:0] ssp0;
        logic [23:0] vaddr;
        logic [95:0] stk;
        int          wr_before;
    } exp_t;

    logic clk = 0, rst = 1, start = 0;
    logic [7:0] irq_num = 0; logic [2:0] irq_level = 0; logic irq_mode = 0;
    logic [15:0] ps_in = 0, pc_in = 0, ssp_in = 0;
    logic [7:0] pcb_in = 0, dtb_in = 0, adb_in = 0, dpr_in = 0, ssb_in = 0;
    logic [31:0] acc_in = 0;
    logic mem_req, mem_we, mem_ack = 0, busy, branch, svc_req;
    logic [23:0] mem_addr; logic [7:0] mem_wdata, mem_rdata = 0;
    logic [15:0] pc_out, ps_out, ssp_out; logic [7:0] pcb_out;

    irq_entry_seq #(.NUM_W(8), .VEC_BASE(VB)) i_irq_entry_seq (.*);

    always #2.5 clk = ~clk;

    int total = 0, fails = 0, writes = 0, max_wait = 0, rd_n = 0;
    logic [23:0] rd_log [3];
    logic [7:0] mem [logic [23:0]];
    exp_t q [$];
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory responder with random wait states; also checks request stability (R8).
    initial begin
        bit pend = 0; int wl = 0; logic [23:0] ha = 0; logic [7:0] hd = 0; bit hw = 0; bit held = 1;
        forever begin
            @(negedge clk);
            mem_ack = 0;
            if (!rst && mem_req) begin
                if (!pend) begin
                    pend = 1; ha = mem_addr; hd = mem_wdata; hw = mem_we; held = 1;
                    wl = $urandom_range(0, max_wait);
                end else if (mem_addr !== ha || mem_we !== hw || (hw && mem_wdata !== hd)) held = 0;
                if (wl == 0) begin
                    chk(held, "R8 request held during wait", {8'h0, mem_addr}, {8'h0, ha});
                    mem_ack = 1; pend = 0;
                    if (mem_we) begin mem[mem_addr] = mem_wdata; writes++; end
                    else begin
                        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
                        if (rd_n < 3) rd_log[rd_n] = mem_addr;
                        rd_n++;
                    end
                end else wl--;
            end
        end
    end

    // Monitor: pops expected items as results appear.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst && (branch || svc_req)) begin
                if (q.size() == 0) chk(0, "R2/R9 unexpected result", 1, 0);
                else begin
                    e = q.pop_front();
                    if (e.svc) begin
                        chk(svc_req && !branch, "R2 service pulse only", {30'h0, svc_req, branch}, 2);
                        chk(writes == e.wr_before, "R2 no stack writes", writes, e.wr_before);
                        chk(rd_n == 0, "R2 no reads", rd_n, 0);
                        @(negedge clk);
                        chk(!svc_req && !busy, "R2 single pulse, idle", {svc_req, busy}, 0);
                    end else begin
                        chk(branch, "R9 branch expected", branch, 1);
                        for (int k = 0; k < 12; k++) begin
                            logic [23:0] a;
                            logic [7:0] exb;
                            a = {e.ssb, 16'(e.ssp0 - 16'(k + 1))};
                            exb = e.stk[8*(11-k) +: 8];
                            chk(mem.exists(a) && mem[a] == exb, "R3 stacked byte", mem.exists(a) ? mem[a] : 8'hxx, exb);
                        end
                        chk(writes == e.wr_before + 12, "R3 write count", writes, e.wr_before + 12);
                        for (int k = 0; k < 3; k++)
                            chk(rd_n == 3 && rd_log[k] == e.vaddr + 24'(k), "R4 vector read address", rd_log[k], e.vaddr + 24'(k));
                        chk(pc_out == e.pc, "R5 pc_out", pc_out, e.pc);
                        chk(pcb_out == e.pcb, "R5 pcb_out", pcb_out, e.pcb);
                        chk(ps_out == e.ps, "R6 ps_out", ps_out, e.ps);
                        chk(ssp_out == e.ssp, "R7 ssp_out", ssp_out, e.ssp);
                        @(negedge clk);
                        chk(!branch && !busy, "R9 single pulse, idle", {branch, busy}, 0);
                    end
                end
            end
        end
    end

    task automatic run_case(input logic [15:0] ps, input logic [15:0] pc, input logic [7:0] pcb,
                            input logic [7:0] dtb, input logic [7:0] adb, input logic [7:0] dpr,
                            input logic [31:0] acc, input logic [7:0] ssb, input logic [15:0] ssp,
                            input logic [7:0] num, input logic [2:0] lvl, input bit mode, input bit poke);
        exp_t e;
        logic [7:0] v [3];
        logic [15:0] p;
        e.vaddr = VB - {14'h0, num, 2'b00};
        for (int k = 0; k < 3; k++) begin v[k] = 8'($urandom); mem[e.vaddr + 24'(k)] = v[k]; end
        p = ps; p[15:13] = lvl; p[5] = 1'b1;
        e.svc = mode; e.pc = {v[1], v[0]}; e.pcb = v[2]; e.ps = p;
        e.ssp = ssp - 16'd12; e.ssb = ssb; e.ssp0 = ssp;
        e.stk = {ps, pc, pcb, dtb, adb, dpr, acc};
        e.wr_before = writes;
        q.push_back(e);
        rd_n = 0;
        @(negedge clk);
        ps_in = ps; pc_in = pc; pcb_in = pcb; dtb_in = dtb; adb_in = adb; dpr_in = dpr;
        acc_in = acc; ssb_in = ssb; ssp_in = ssp; irq_num = num; irq_level = lvl; irq_mode = mode;
        start = 1;
        @(negedge clk);
        start = 0;
        if (poke) begin  // R10: second start with other context while busy
            repeat (3) @(negedge clk);
            ps_in = ~ps; pc_in = ~pc; acc_in = ~acc; ssp_in = ssp + 16'd100; ssb_in = ~ssb;
            irq_num = ~num; irq_level = ~lvl; irq_mode = ~mode; start = 1;
            @(negedge clk);
            start = 0;
        end
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(q.size() == 0, "R10 one result per accepted start", q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !mem_req && !branch && !svc_req, "R1 reset state",
            {busy, mem_req, branch, svc_req}, 0);
        max_wait = 0;
        run_case(16'h1234, 16'h5678, 8'h9A, 8'hBC, 8'hDE, 8'hF0, 32'h0A1B2C3D, 8'h12, 16'h8000, 8'd7, 3'd5, 0, 0);
        max_wait = 3;
        run_case(16'hFFFF, 16'hCAFE, 8'h01, 8'h02, 8'h03, 8'h04, 32'hDEADBEEF, 8'h40, 16'h0005, 8'd0, 3'd0, 0, 0);
        run_case(16'h0000, 16'h1111, 8'h22, 8'h33, 8'h44, 8'h55, 32'h66778899, 8'h7E, 16'h4000, 8'd255, 3'd7, 0, 0);
        run_case(16'hA5A5, 16'h0102, 8'h03, 8'h04, 8'h05, 8'h06, 32'h0708090A, 8'h20, 16'h2000, 8'd9, 3'd2, 1, 0);
        run_case(16'h5A5A, 16'h2468, 8'h13, 8'h57, 8'h9B, 8'hDF, 32'h11223344, 8'h33, 16'h1000, 8'd42, 3'd4, 0, 1);
        for (int i = 0; i < 6; i++) begin
            max_wait = i % 4;
            run_case(16'($urandom), 16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                     $urandom, 8'($urandom_range(0, 254)), 16'($urandom), 8'($urandom), 3'($urandom), 0, 0);
        end
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule